// File: doc/BRIEF.md
# Countdown Watchdog with Selectable Time Base and Reset Output Shape

This block is a hardware watchdog that sits behind a small register port. Software loads an 8-bit countdown value, picks whether each count lasts one second or one minute, and arms the timer. A free-running 1 ms tick input is divided down inside the block to produce the second and minute steps. If software does not rewrite the countdown register before it runs out, the block drives an active-low reset request. That request is either a held level or a single pulse whose width comes from a 2-bit code.

Every expiry sets a timeout flag. Software clears it by writing a one to it. The flag is held on a separate power-on reset, so it keeps its value through the ordinary reset that the watchdog itself triggers. After the system restarts, firmware can read the flag to learn that the last restart came from the watchdog. Counting takes place only while both the run bit and the device-enable bit are set. The reset output reaches the pin only while the output-enable bit is set.

Top module: `wdog_unit`

## Requirements
- R1: Once both resets are released, `wdt_rst_no` is 1, `tmo_o` is 0, and all three registers read 0: CTRL at address 0, TIME at address 1, PINCFG at address 2.
- R2: In seconds mode (CTRL bit 1 = 0), a TIME write of N>0 with the timer active makes the output assert exactly N*TICKS_PER_SEC ticks after the write edge.
- R3: In minutes mode (CTRL bit 1 = 1), the same write makes the output assert after N*TICKS_PER_SEC*SEC_PER_MIN ticks.
- R4: A TIME write reloads the counter and restarts the tick divider, so it works as the keepalive. A read of TIME returns the current remaining count.
- R5: The timer is active only while CTRL bit 0 (run) and PINCFG bit 0 (device enable) are both 1. While it is inactive the count does not change.
- R6: In level mode (CTRL bit 2 = 0), the output stays asserted after expiry. It releases in the cycle after a write that clears run, or after a TIME write.
- R7: In pulse mode (CTRL bit 2 = 1), the output asserts for a number of ticks set by the code in CTRL bits 4:3. Codes 0, 1, 2 and 3 select PW_CODE0_MS, PW_CODE1_MS, PW_CODE2_MS and PW_CODE3_MS (defaults 1, 25, 125 and 5000 ms). The output then releases.
- R8: Each expiry sets the status bit (`tmo_o`, readable as CTRL bit 7). Writing 1 to CTRL bit 7 clears it. Writing 0 to that bit leaves it unchanged.
- R9: The status bit survives `rst_ni` and is cleared only by `por_ni`. `rst_ni` clears all other state.
- R10: While PINCFG bit 1 (output enable) is 0, `wdt_rst_no` stays 1, but an expiry still sets the status bit.
- R11: A TIME value of 0 never produces an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, async assert, sync release; clears all but status |
| por_ni | input | 1 | Active-low power-on reset; clears the timeout status |
| tick_i | input | 1 | One-cycle 1 ms time base strobe |
| addr_i | input | 2 | Register address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| tmo_o | output | 1 | Sticky timeout status |
| wdt_rst_no | output | 1 | Active-low watchdog reset request |

## Verification
Faults inside the block show up at the ports in specific ways. A divider or counter that steps at the wrong rate moves the expiry edge of `wdt_rst_no` by at least one tick, and the bench catches this by checking the pin one tick before and exactly at the computed deadline. A wrong count also appears at once on a TIME read. A stuck or wrongly reset status bit shows on `tmo_o` in the cycle after the write or reset that should have changed it. Faults in pulse length or release logic change the pin within the width window, which the bench brackets on both sides.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 8;

  // register addresses
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_TIME = 2'd1;
  localparam logic [ADDR_W-1:0] A_PIN  = 2'd2;

  // CTRL bit positions
  localparam int unsigned B_RUN   = 0;
  localparam int unsigned B_MIN   = 1;
  localparam int unsigned B_PULSE = 2;
  localparam int unsigned B_WLO   = 3;
  localparam int unsigned B_WHI   = 4;
  localparam int unsigned B_STS   = 7;
  // PINCFG bit positions
  localparam int unsigned B_DEV   = 0;
  localparam int unsigned B_OUT   = 1;

  typedef struct packed {
    logic       run;
    logic       minutes;
    logic       pulse;
    logic [1:0] width;
    logic       dev_en;
    logic       out_en;
  } cfg_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic              expire_i,
  output cfg_t              cfg_o,
  output logic              status_o,
  output logic              load_o,
  output logic [DATA_W-1:0] rdata_o
);
  cfg_t cfg_q, cfg_d;
  logic sts_q, sts_d;
  logic wr_ctrl, wr_pin, cfg_en;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[6:5];

  always_comb begin
    wr_ctrl = we_i && (addr_i == A_CTRL);
    wr_pin  = we_i && (addr_i == A_PIN);
    load_o  = we_i && (addr_i == A_TIME);
    cfg_en  = wr_ctrl || wr_pin;
    cfg_d   = cfg_q;
    if (wr_ctrl) begin
      cfg_d.run     = wdata_i[B_RUN];
      cfg_d.minutes = wdata_i[B_MIN];
      cfg_d.pulse   = wdata_i[B_PULSE];
      cfg_d.width   = wdata_i[B_WHI:B_WLO];
    end
    if (wr_pin) begin
      cfg_d.dev_en = wdata_i[B_DEV];
      cfg_d.out_en = wdata_i[B_OUT];
    end
    sts_d = sts_q;
    if (wr_ctrl && wdata_i[B_STS]) sts_d = 1'b0;
    if (expire_i)                  sts_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  // status lives on the power-on reset only
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) sts_q <= 1'b0;
    else         sts_q <= sts_d;
  end

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = {sts_q, 2'b00, cfg_q.width, cfg_q.pulse, cfg_q.minutes, cfg_q.run};
      A_TIME:  rdata_o = count_i;
      A_PIN:   rdata_o = {6'b0, cfg_q.out_en, cfg_q.dev_en};
      default: rdata_o = '0;
    endcase
  end

  assign cfg_o    = cfg_q;
  assign status_o = sts_q;
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int unsigned TICKS_PER_SEC = 1000,
  parameter int unsigned SEC_PER_MIN   = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic restart_i,
  input  logic minutes_i,
  output logic step_o
);
  localparam int unsigned MS_W = $clog2(TICKS_PER_SEC + 1);

  logic [MS_W-1:0] ms_q, ms_d;
  logic ms_en, ms_wrap, sec_last, clr;

  always_comb begin
    clr     = !run_i || restart_i;
    ms_wrap = (ms_q == MS_W'(TICKS_PER_SEC - 1));
    ms_en   = clr || tick_i;
    if (clr)          ms_d = '0;
    else if (ms_wrap) ms_d = '0;
    else              ms_d = ms_q + MS_W'(1);
    step_o  = !clr && tick_i && ms_wrap && (!minutes_i || sec_last);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ms_q <= '0;
    else if (ms_en) ms_q <= ms_d;
  end

  generate
    if (SEC_PER_MIN > 1) begin : g_min
      localparam int unsigned SEC_W = $clog2(SEC_PER_MIN + 1);
      logic [SEC_W-1:0] sec_q, sec_d;
      logic sec_en;
      always_comb begin
        sec_last = (sec_q == SEC_W'(SEC_PER_MIN - 1));
        sec_en   = clr || (tick_i && ms_wrap);
        if (clr || sec_last) sec_d = '0;
        else                 sec_d = sec_q + SEC_W'(1);
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     sec_q <= '0;
        else if (sec_en) sec_q <= sec_d;
      end
    end else begin : g_nomin
      assign sec_last = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic cnt_en;

  always_comb begin
    cnt_en   = load_i || step_i;
    cnt_d    = load_i ? load_val_i : (cnt_q - CNT_W'(1));
    expire_o = step_i && !load_i && (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/wdog_outgen.sv
module wdog_outgen #(
  parameter int unsigned PW_CODE0_MS = 1,
  parameter int unsigned PW_CODE1_MS = 25,
  parameter int unsigned PW_CODE2_MS = 125,
  parameter int unsigned PW_CODE3_MS = 5000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       expire_i,
  input  logic       active_i,
  input  logic       reload_i,
  input  logic       pulse_mode_i,
  input  logic [1:0] width_i,
  input  logic       out_en_i,
  output logic       fire_o,
  output logic       wdt_rst_no
);
  localparam int unsigned PW_M01 = (PW_CODE0_MS > PW_CODE1_MS) ? PW_CODE0_MS : PW_CODE1_MS;
  localparam int unsigned PW_M23 = (PW_CODE2_MS > PW_CODE3_MS) ? PW_CODE2_MS : PW_CODE3_MS;
  localparam int unsigned PW_MAX = (PW_M01 > PW_M23) ? PW_M01 : PW_M23;
  localparam int unsigned PW_W   = $clog2(PW_MAX + 1);

  function automatic logic [PW_W-1:0] width_ticks(input logic [1:0] code);
    case (code)
      2'd0:    width_ticks = PW_W'(PW_CODE0_MS);
      2'd1:    width_ticks = PW_W'(PW_CODE1_MS);
      2'd2:    width_ticks = PW_W'(PW_CODE2_MS);
      default: width_ticks = PW_W'(PW_CODE3_MS);
    endcase
  endfunction

  logic            fire_q, fire_d, en;
  logic [PW_W-1:0] left_q, left_d;

  always_comb begin
    fire_d = fire_q;
    left_d = left_q;
    en     = expire_i || fire_q;
    if (expire_i) begin
      fire_d = 1'b1;
      left_d = width_ticks(width_i);
    end else if (!active_i || reload_i) begin
      fire_d = 1'b0;
      left_d = '0;
    end else if (pulse_mode_i && tick_i) begin
      if (left_q <= PW_W'(1)) begin
        fire_d = 1'b0;
        left_d = '0;
      end else begin
        left_d = left_q - PW_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fire_q <= 1'b0;
      left_q <= '0;
    end else if (en) begin
      fire_q <= fire_d;
      left_q <= left_d;
    end
  end

  assign fire_o     = fire_q;
  assign wdt_rst_no = !(fire_q && out_en_i && active_i);
endmodule

// File: rtl/wdog_unit.sv
module wdog_unit
  import wdog_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 1000,
  parameter int unsigned SEC_PER_MIN   = 60,
  parameter int unsigned PW_CODE0_MS   = 1,
  parameter int unsigned PW_CODE1_MS   = 25,
  parameter int unsigned PW_CODE2_MS   = 125,
  parameter int unsigned PW_CODE3_MS   = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              tmo_o,
  output logic              wdt_rst_no
);
  cfg_t              cfg;
  logic              load, step, expire, fire, active, counting;
  logic              run_en, dev_en, out_en, pulse_mode;
  logic [DATA_W-1:0] count;

  assign run_en     = cfg.run;
  assign dev_en     = cfg.dev_en;
  assign out_en     = cfg.out_en;
  assign pulse_mode = cfg.pulse;
  assign active     = run_en && dev_en;
  assign counting   = active && (count != '0);

  wdog_regs u_regs (
    .clk_i, .rst_ni, .por_ni, .addr_i, .we_i, .wdata_i,
    .count_i(count), .expire_i(expire), .cfg_o(cfg),
    .status_o(tmo_o), .load_o(load), .rdata_o
  );

  wdog_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC), .SEC_PER_MIN(SEC_PER_MIN)) u_pre (
    .clk_i, .rst_ni, .tick_i, .run_i(counting), .restart_i(load),
    .minutes_i(cfg.minutes), .step_o(step)
  );

  wdog_count #(.CNT_W(DATA_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(wdata_i), .step_i(step),
    .count_o(count), .expire_o(expire)
  );

  wdog_outgen #(.PW_CODE0_MS(PW_CODE0_MS), .PW_CODE1_MS(PW_CODE1_MS),
                .PW_CODE2_MS(PW_CODE2_MS), .PW_CODE3_MS(PW_CODE3_MS)) u_out (
    .clk_i, .rst_ni, .tick_i, .expire_i(expire), .active_i(active),
    .reload_i(load), .pulse_mode_i(pulse_mode), .width_i(cfg.width),
    .out_en_i(out_en), .fire_o(fire), .wdt_rst_no
  );
endmodule

// File: rtl/wdog_unit_chk.sv
module wdog_unit_chk
  import wdog_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              por_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              active,
  input logic [DATA_W-1:0] count,
  input logic              fire,
  input logic              pulse_mode,
  input logic              out_en,
  input logic              status,
  input logic              pin
);
  logic time_wr, ctrl_wr;
  assign time_wr = we_i && (addr_i == A_TIME);
  assign ctrl_wr = we_i && (addr_i == A_CTRL);

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && !time_wr) |=> $stable(count));

  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !time_wr |=> (count == $past(count) || count == $past(count) - DATA_W'(1)));

  // R11
  zero_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count == '0 && !fire && !time_wr) |=> !fire);

  // R6
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !pulse_mode && active && !we_i) |=> fire);

  // R6
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !wdata_i[B_RUN]) |=> pin);

  // R10
  pin_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en |-> pin);

  // R8
  status_keep_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    (status && !(ctrl_wr && wdata_i[B_STS])) |=> status);

  // R8
  status_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    $rose(fire) |-> status);
endmodule

bind wdog_unit wdog_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .por_ni(por_ni), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .active(active), .count(count),
  .fire(fire), .pulse_mode(pulse_mode), .out_en(out_en),
  .status(tmo_o), .pin(wdt_rst_no)
);

// File: tb/wdog_unit_bench.sv
module wdog_unit_bench;
  import wdog_pkg::*;

  localparam int TPS = 4;
  localparam int SPM = 3;

  function automatic int pw(input int c);
    case (c)
      0: pw = 1;
      1: pw = 2;
      2: pw = 5;
      default: pw = 9;
    endcase
  endfunction

  logic clk_i = 1'b0;
  logic rst_ni, por_ni, tick_i, we_i;
  logic [ADDR_W-1:0] addr_i;
  logic [DATA_W-1:0] wdata_i, rdata_o;
  logic tmo_o, wdt_rst_no;
  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  wdog_unit #(.TICKS_PER_SEC(TPS), .SEC_PER_MIN(SPM), .PW_CODE0_MS(1),
              .PW_CODE1_MS(2), .PW_CODE2_MS(5), .PW_CODE3_MS(9)) u_wdog_unit (
    .clk_i, .rst_ni, .por_ni, .tick_i, .addr_i, .we_i, .wdata_i,
    .rdata_o, .tmo_o, .wdt_rst_no
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // write lands on the next rising edge; returns at the following negedge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; por_ni = 1'b0; we_i = 1'b0; addr_i = '0; wdata_i = '0; tick_i = 1'b1;
    idle(3);
    rst_ni = 1'b1; por_ni = 1'b1;
    idle(1);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 pin", wdt_rst_no, 1);
    chk("R1 tmo", tmo_o, 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_TIME, v); chk("R1 time", v, 0);
    rd(A_PIN, v);  chk("R1 pincfg", v, 0);
  endtask

  task automatic t_seconds();
    logic [7:0] v;
    wr(A_PIN, 8'h03);
    wr(A_CTRL, 8'h01);
    wr(A_TIME, 8'd3);
    idle(3*TPS - 1);
    chk("R2 before deadline", wdt_rst_no, 1);
    rd(A_TIME, v); chk("R4 count readback", v, 1);
    idle(1);
    chk("R2 at deadline", wdt_rst_no, 0);
    chk("R8 status set", tmo_o, 1);
    rd(A_CTRL, v); chk("R8 status in ctrl", v, 8'h81);
    idle(20);
    chk("R6 level held", wdt_rst_no, 0);
    wr(A_CTRL, 8'h01);
    chk("R8 write 0 keeps status", tmo_o, 1);
    chk("R6 ctrl rewrite keeps level", wdt_rst_no, 0);
    wr(A_CTRL, 8'h80);
    chk("R6 stop releases", wdt_rst_no, 1);
    chk("R8 w1c", tmo_o, 0);
  endtask

  task automatic t_keepalive();
    logic [7:0] v;
    wr(A_CTRL, 8'h01);
    wr(A_TIME, 8'd2);
    idle(6);
    wr(A_TIME, 8'd2);
    idle(7);
    chk("R4 keepalive postpones", wdt_rst_no, 1);
    idle(1);
    chk("R4 expiry after reload", wdt_rst_no, 0);
    wr(A_TIME, 8'd5);
    chk("R6 reload releases", wdt_rst_no, 1);
    wr(A_CTRL, 8'h81);
    wr(A_TIME, 8'd0);
    idle(50);
    chk("R11 zero no fire", wdt_rst_no, 1);
    chk("R11 zero no status", tmo_o, 0);
    rd(A_TIME, v); chk("R11 count stays 0", v, 0);
  endtask

  task automatic t_gate();
    logic [7:0] v;
    wr(A_PIN, 8'h02);
    wr(A_TIME, 8'd1);
    idle(20);
    chk("R5 no dev_en no fire", wdt_rst_no, 1);
    rd(A_TIME, v); chk("R5 count frozen", v, 1);
    wr(A_PIN, 8'h03);
    idle(TPS - 1);
    chk("R5 enable starts count", wdt_rst_no, 1);
    idle(1);
    chk("R5 expiry after enable", wdt_rst_no, 0);
    wr(A_CTRL, 8'h80);
    wr(A_CTRL, 8'h00);
    wr(A_TIME, 8'd1);
    idle(20);
    chk("R5 no run no fire", wdt_rst_no, 1);
    chk("R5 no run no status", tmo_o, 0);
  endtask

  task automatic t_minutes();
    wr(A_CTRL, 8'h03);
    wr(A_TIME, 8'd2);
    idle(2*TPS*SPM - 1);
    chk("R3 before minute deadline", wdt_rst_no, 1);
    idle(1);
    chk("R3 at minute deadline", wdt_rst_no, 0);
    wr(A_CTRL, 8'h80);
  endtask

  task automatic t_pulse();
    for (int c = 0; c < 4; c++) begin
      wr(A_CTRL, 8'h80);
      wr(A_CTRL, 8'h05 | 8'(c << 3));
      wr(A_TIME, 8'd1);
      idle(TPS);
      chk($sformatf("R7 code %0d asserted", c), wdt_rst_no, 0);
      idle(pw(c) - 1);
      chk($sformatf("R7 code %0d last tick", c), wdt_rst_no, 0);
      idle(1);
      chk($sformatf("R7 code %0d released", c), wdt_rst_no, 1);
      chk($sformatf("R8 code %0d status", c), tmo_o, 1);
    end
    wr(A_CTRL, 8'h80);
  endtask

  task automatic t_outen();
    wr(A_PIN, 8'h01);
    wr(A_CTRL, 8'h01);
    wr(A_TIME, 8'd1);
    idle(TPS + 3);
    chk("R10 gated pin", wdt_rst_no, 1);
    chk("R10 status still set", tmo_o, 1);
    wr(A_PIN, 8'h03);
    chk("R10 ungated pin", wdt_rst_no, 0);
  endtask

  task automatic t_por();
    logic [7:0] v;
    rst_ni = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
    chk("R9 status survives rst", tmo_o, 1);
    chk("R9 pin released by rst", wdt_rst_no, 1);
    rd(A_CTRL, v); chk("R9 ctrl after rst", v, 8'h80);
    rd(A_PIN, v);  chk("R9 pincfg after rst", v, 0);
    por_ni = 1'b0;
    idle(2);
    por_ni = 1'b1;
    idle(1);
    chk("R9 por clears status", tmo_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_seconds();
    t_keepalive();
    t_gate();
    t_minutes();
    t_pulse();
    t_outen();
    t_por();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule